// File: doc/BRIEF.md
# Standby power sequencer

This block sequences the low-power modes of a small microcontroller. When the CPU signals a sleep instruction, the block samples a deep-standby enable bit. If the bit is set, it stops every clock, stops the oscillator and holds the peripherals in reset. CPU registers and RAM keep their contents, which the block shows with a retain flag. If the bit is clear, it enters a light nap in which only the CPU clock is gated.

Leaving deep standby takes one of three paths:
- A qualified interrupt restarts the oscillator. The block then waits a programmable number of settling cycles and starts interrupt exception handling.
- A low reset pin restarts the oscillator. Reset exception handling starts when the pin goes high again.
- A low hold pin sends the block to a separate hardware-hold state. That state is left only through a full reset sequence.

The block itself runs on a free-running control clock. Its outputs are the enables that a clock-gating cell and the oscillator act on.

Top module: `pmc_standby_ctrl`

## Requirements
- R1: From the run state, a `sleep_req` pulse with `deep_en`=1 enters deep standby. A `sleep_req` that arrives in any other state has no effect.
- R2: In deep standby, `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R3: Deep standby asserts `periph_rst`. Entering it sets `retain` to 1.
- R4: In deep standby, only these sources wake the block: `nmi`, and lines 0, 1, 2 and 6 of `irq_req` when the matching `irq_en` bit is 1. Line 6 is also raised by any bit of `key_in`.
- R5: Lines 3, 4, 5 and 7 never wake deep standby. On entry, `cfg_err` is set to 1 if any of `irq_en[3]`, `irq_en[4]`, `irq_en[5]` or `irq_en[7]` is 1, and to 0 otherwise.
- R6: After a qualified wake, `osc_en`=1 with the clocks gated for exactly 2^(SETTLE_BASE+min(`settle_sel`,5)) cycles. In the next cycle both clocks are enabled and `irq_exc_start` is high for one cycle.
- R7: Wake requests that arrive during the settling countdown are ignored and do not restart it.
- R8: A low `rst_pin_n` in deep standby or during settling enables the oscillator and holds the clocks gated. The cycle after the pin is seen high, the clocks run and `rst_exc_start` pulses once.
- R9: A low `hold_pin_n` in any state wins over every other input. It enters hardware hold: `hw_hold`=1, `periph_rst`=1, `osc_en`=0, both clocks gated, `retain` cleared.
- R10: When `hold_pin_n` returns high, the block enters a reset wait: `hw_hold`=0, `osc_en`=1, `periph_rst`=1. A `rst_exc_start` pulse follows. `retain` stays 0.
- R11: `sleep_req` with `deep_en`=0 enters nap: `cpu_clk_en`=0, `periph_clk_en`=1, `periph_rst`=0. Any enabled `irq_req` line or `nmi` returns the block to run, with an `irq_exc_start` pulse.
- R12: After reset the block is in run: both clocks and the oscillator enabled, `periph_rst`, `hw_hold`, `retain`, `cfg_err` and both start pulses all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst | input | 1 | Synchronous active-high reset |
| deep_en | input | 1 | Selects deep standby (1) or nap (0) on sleep |
| settle_sel | input | 3 | Oscillator settling-time select |
| irq_en | input | 8 | Per-line interrupt enables |
| sleep_req | input | 1 | One-cycle strobe from the sleep instruction |
| rst_pin_n | input | 1 | Reset pin, active low |
| hold_pin_n | input | 1 | Hardware-hold pin, active low |
| nmi | input | 1 | Non-maskable interrupt request |
| irq_req | input | 8 | Interrupt request lines |
| key_in | input | KEY_LINES | Key inputs, ORed into line 6 |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| periph_rst | output | 1 | Peripheral reset |
| hw_hold | output | 1 | Hardware-hold indication |
| irq_exc_start | output | 1 | One-cycle start of interrupt exception handling |
| rst_exc_start | output | 1 | One-cycle start of reset exception handling |
| retain | output | 1 | CPU register and RAM contents valid |
| cfg_err | output | 1 | Non-waking line was enabled at standby entry |

## Verification
In deep standby a wake request can arrive in the same cycle as a falling reset pin or a falling hold pin, and each pair must resolve by priority. The bench drives `nmi` together with a low `rst_pin_n`. It requires that the clocks stay gated and that no interrupt start appears, even after the shortest settling time has passed, and that only `rst_exc_start` follows the pin's release. It also drives `nmi` together with a low `hold_pin_n` and requires hardware hold with `retain` cleared. Random interrupt patterns with random enables and settling selects are also applied, some with extra wake requests during the countdown. The wake decision and cycle count from bench functions are compared with the measured gap before `irq_exc_start`.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_RUN,
        PM_NAP,
        PM_DEEP,
        PM_SETTLE,
        PM_RSTWAIT,
        PM_HOLD
    } pm_state_e;

    localparam int unsigned IRQ_LINES = 8;
    localparam int unsigned KEY_LINE  = 6;
    localparam int unsigned SEL_CAP   = 5;

    // lines allowed to wake deep standby, and lines that must be disabled first
    localparam logic [IRQ_LINES-1:0] DEEP_WAKE_MASK = 8'b0100_0111;
    localparam logic [IRQ_LINES-1:0] DEEP_BAD_MASK  = 8'b1011_1000;

    typedef struct packed {
        logic cpu_clk_en;
        logic periph_clk_en;
        logic osc_en;
        logic periph_rst;
        logic hw_hold;
    } pm_ctl_t;

    function automatic pm_ctl_t ctl_for(pm_state_e s);
        pm_ctl_t c;
        case (s)
            PM_RUN:     c = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
            PM_NAP:     c = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
            PM_DEEP:    c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
            PM_SETTLE:  c = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
            PM_RSTWAIT: c = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
            PM_HOLD:    c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
            default:    c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
        endcase
        return c;
    endfunction

    function automatic int unsigned settle_cycles(int unsigned base, logic [2:0] sel);
        int unsigned s;
        s = (int'(sel) > SEL_CAP) ? SEL_CAP : int'(sel);
        return 32'd1 << (base + s);
    endfunction

endpackage

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual
    import pmc_pkg::*;
#(
    parameter int KEY_LINES = 16
) (
    input  logic                 nmi,
    input  logic [IRQ_LINES-1:0] irq_req,
    input  logic [IRQ_LINES-1:0] irq_en,
    input  logic [KEY_LINES-1:0] key_in,
    output logic                 wake_deep,
    output logic                 wake_nap,
    output logic                 cfg_bad
);
    logic [IRQ_LINES-1:0] req_eff;
    logic [IRQ_LINES-1:0] live;

    for (genvar g = 0; g < IRQ_LINES; g++) begin : g_line
        if (g == KEY_LINE) begin : g_key
            assign req_eff[g] = irq_req[g] | (|key_in);
        end else begin : g_plain
            assign req_eff[g] = irq_req[g];
        end
        assign live[g] = req_eff[g] & irq_en[g];
    end

    assign wake_deep = nmi | (|(live & DEEP_WAKE_MASK));
    assign wake_nap  = nmi | (|live);
    assign cfg_bad   = |(irq_en & DEEP_BAD_MASK);

    // r5: a deep wake always implies a nap wake
    always_comb begin
        a_r5_deep_subset: assert (!wake_deep || wake_nap);
    end

endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer
    import pmc_pkg::*;
#(
    parameter int SETTLE_BASE = 13,
    parameter int CNT_W       = SETTLE_BASE + 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       done
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    assign load_val = CNT_W'(settle_cycles(SETTLE_BASE, sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (!run) begin
            cnt_q <= '0;
        end
    end

    assign done = run && (cnt_q == CNT_W'(1));

    a_r6_loaded_nonzero: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> (cnt_q >= CNT_W'(2)));

    a_r7_no_reload_in_countdown: assert property (@(posedge clk) disable iff (rst)
        run |-> !load);

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      deep_en,
    input  logic      sleep_req,
    input  logic      rst_pin_n,
    input  logic      hold_pin_n,
    input  logic      wake_deep,
    input  logic      wake_nap,
    input  logic      cfg_bad,
    input  logic      tmr_done,
    output pm_state_e state,
    output logic      tmr_load,
    output logic      tmr_run,
    output logic      irq_exc_start,
    output logic      rst_exc_start,
    output logic      retain,
    output logic      cfg_err
);
    pm_state_e st_q, st_d;
    logic      go_irq, go_rst;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        go_irq   = 1'b0;
        go_rst   = 1'b0;
        if (!hold_pin_n) begin
            st_d = PM_HOLD;
        end else begin
            case (st_q)
                PM_RUN: if (sleep_req) st_d = deep_en ? PM_DEEP : PM_NAP;
                PM_NAP: if (wake_nap) begin
                    st_d   = PM_RUN;
                    go_irq = 1'b1;
                end
                PM_DEEP: begin
                    if (!rst_pin_n) begin
                        st_d = PM_RSTWAIT;
                    end else if (wake_deep) begin
                        st_d     = PM_SETTLE;
                        tmr_load = 1'b1;
                    end
                end
                PM_SETTLE: begin
                    if (!rst_pin_n) begin
                        st_d = PM_RSTWAIT;
                    end else if (tmr_done) begin
                        st_d   = PM_RUN;
                        go_irq = 1'b1;
                    end
                end
                PM_RSTWAIT: if (rst_pin_n) begin
                    st_d   = PM_RUN;
                    go_rst = 1'b1;
                end
                PM_HOLD: st_d = PM_RSTWAIT;
                default: st_d = PM_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= PM_RUN;
            irq_exc_start <= 1'b0;
            rst_exc_start <= 1'b0;
            retain        <= 1'b0;
            cfg_err       <= 1'b0;
        end else begin
            st_q          <= st_d;
            irq_exc_start <= go_irq;
            rst_exc_start <= go_rst;
            if (st_d == PM_HOLD) begin
                retain <= 1'b0;
            end else if (st_q == PM_RUN && st_d == PM_DEEP) begin
                retain  <= 1'b1;
                cfg_err <= cfg_bad;
            end
        end
    end

    assign state   = st_q;
    assign tmr_run = (st_q == PM_SETTLE);

    a_r9_hold_wins: assert property (@(posedge clk) disable iff (rst)
        !hold_pin_n |=> (st_q == PM_HOLD));

    a_r6_irq_after_count: assert property (@(posedge clk) disable iff (rst)
        irq_exc_start |-> (($past(st_q) == PM_SETTLE && $past(tmr_done)) || $past(st_q) == PM_NAP));

    a_r8_rst_exc_on_high_pin: assert property (@(posedge clk) disable iff (rst)
        rst_exc_start |-> ($past(rst_pin_n) && $past(st_q) == PM_RSTWAIT));

    a_r5_deep_stays: assert property (@(posedge clk) disable iff (rst)
        (st_q == PM_DEEP && hold_pin_n && rst_pin_n && !wake_deep) |=> (st_q == PM_DEEP));

    a_r12_one_start: assert property (@(posedge clk) disable iff (rst)
        !(irq_exc_start && rst_exc_start));

endmodule

// File: rtl/pmc_standby_ctrl.sv
module pmc_standby_ctrl
    import pmc_pkg::*;
#(
    parameter int SETTLE_BASE = 13,
    parameter int KEY_LINES   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 deep_en,
    input  logic [2:0]           settle_sel,
    input  logic [7:0]           irq_en,
    input  logic                 sleep_req,
    input  logic                 rst_pin_n,
    input  logic                 hold_pin_n,
    input  logic                 nmi,
    input  logic [7:0]           irq_req,
    input  logic [KEY_LINES-1:0] key_in,
    output logic                 cpu_clk_en,
    output logic                 periph_clk_en,
    output logic                 osc_en,
    output logic                 periph_rst,
    output logic                 hw_hold,
    output logic                 irq_exc_start,
    output logic                 rst_exc_start,
    output logic                 retain,
    output logic                 cfg_err
);
    localparam int CNT_W = SETTLE_BASE + 7;

    logic      wake_deep, wake_nap, cfg_bad;
    logic      tmr_load, tmr_run, tmr_done;
    pm_state_e state;
    pm_ctl_t   ctl;

    pmc_wake_qual #(.KEY_LINES(KEY_LINES)) u_qual (
        .nmi       (nmi),
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .key_in    (key_in),
        .wake_deep (wake_deep),
        .wake_nap  (wake_nap),
        .cfg_bad   (cfg_bad)
    );

    pmc_settle_timer #(.SETTLE_BASE(SETTLE_BASE), .CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .run  (tmr_run),
        .sel  (settle_sel),
        .done (tmr_done)
    );

    pmc_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .deep_en       (deep_en),
        .sleep_req     (sleep_req),
        .rst_pin_n     (rst_pin_n),
        .hold_pin_n    (hold_pin_n),
        .wake_deep     (wake_deep),
        .wake_nap      (wake_nap),
        .cfg_bad       (cfg_bad),
        .tmr_done      (tmr_done),
        .state         (state),
        .tmr_load      (tmr_load),
        .tmr_run       (tmr_run),
        .irq_exc_start (irq_exc_start),
        .rst_exc_start (rst_exc_start),
        .retain        (retain),
        .cfg_err       (cfg_err)
    );

    assign ctl           = ctl_for(state);
    assign cpu_clk_en    = ctl.cpu_clk_en;
    assign periph_clk_en = ctl.periph_clk_en;
    assign osc_en        = ctl.osc_en;
    assign periph_rst    = ctl.periph_rst;
    assign hw_hold       = ctl.hw_hold;

    a_r2_start_needs_clock: assert property (@(posedge clk) disable iff (rst)
        (irq_exc_start || rst_exc_start) |-> (cpu_clk_en && osc_en));

    a_r3_sleep_entry_resets: assert property (@(posedge clk) disable iff (rst)
        (state == PM_RUN && sleep_req && deep_en && hold_pin_n) |=> (periph_rst && retain));

endmodule

// File: tb/tb_pmc_standby_ctrl.sv
module tb_pmc_standby_ctrl;
    localparam int BASE = 2;
    localparam int KL   = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          deep_en = 1'b0;
    logic [2:0]    settle_sel = 3'd0;
    logic [7:0]    irq_en = 8'h00;
    logic          sleep_req = 1'b0;
    logic          rst_pin_n = 1'b1;
    logic          hold_pin_n = 1'b1;
    logic          nmi = 1'b0;
    logic [7:0]    irq_req = 8'h00;
    logic [KL-1:0] key_in = '0;
    logic cpu_clk_en, periph_clk_en, osc_en, periph_rst, hw_hold;
    logic irq_exc_start, rst_exc_start, retain, cfg_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pmc_standby_ctrl #(.SETTLE_BASE(BASE), .KEY_LINES(KL)) dut (
        .clk(clk), .rst(rst), .deep_en(deep_en), .settle_sel(settle_sel),
        .irq_en(irq_en), .sleep_req(sleep_req), .rst_pin_n(rst_pin_n),
        .hold_pin_n(hold_pin_n), .nmi(nmi), .irq_req(irq_req), .key_in(key_in),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
        .periph_rst(periph_rst), .hw_hold(hw_hold), .irq_exc_start(irq_exc_start),
        .rst_exc_start(rst_exc_start), .retain(retain), .cfg_err(cfg_err)
    );

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int exp_cycles(logic [2:0] s);
        return 1 << (BASE + ((s > 3'd5) ? 5 : int'(s)));
    endfunction

    function automatic bit exp_wake(bit n, logic [7:0] rq, logic [7:0] en, logic [KL-1:0] k);
        bit line6;
        line6 = rq[6] || (k != '0);
        return n || (rq[0] && en[0]) || (rq[1] && en[1]) || (rq[2] && en[2]) || (line6 && en[6]);
    endfunction

    function automatic bit exp_bad(logic [7:0] en);
        return en[3] || en[4] || en[5] || en[7];
    endfunction

    task automatic enter_deep(input logic [7:0] en, input logic [2:0] sel);
        irq_en = en; settle_sel = sel; deep_en = 1'b1; sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        chk(cpu_clk_en, 0, "R2", "cpu clock in deep");
        chk(periph_clk_en, 0, "R2", "periph clock in deep");
        chk(osc_en, 0, "R2", "oscillator in deep");
        chk(periph_rst, 1, "R3", "periph reset in deep");
        chk(retain, 1, "R3", "retain in deep");
        chk(cfg_err, exp_bad(en), "R5", "config error flag");
    endtask

    // first settling cycle is already visible; count until the clock returns
    task automatic count_settle(input logic [2:0] sel, input bit noise);
        int n = 0;
        while (!cpu_clk_en && n < 1000) begin
            n++;
            if (!osc_en) begin
                checks++; fails++;
                $display("FAIL R6 oscillator off during settle: actual=0 expected=1");
            end
            if (noise && ($urandom % 2 == 1)) begin
                nmi = 1'b1; irq_req = 8'hFF; // R7: ignored during countdown
            end
            tick();
            nmi = 1'b0; irq_req = 8'h00;
        end
        chk(n, exp_cycles(sel), noise ? "R7" : "R6", "settle cycles");
        chk(irq_exc_start, 1, "R6", "irq start after settle");
        chk(periph_clk_en, 1, "R6", "periph clock after settle");
        tick();
        chk(irq_exc_start, 0, "R6", "irq start single cycle");
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R12 reset state
        chk(cpu_clk_en, 1, "R12", "cpu clock");
        chk(periph_clk_en, 1, "R12", "periph clock");
        chk(osc_en, 1, "R12", "oscillator");
        chk(periph_rst, 0, "R12", "periph reset");
        chk(hw_hold, 0, "R12", "hold flag");
        chk(retain, 0, "R12", "retain");
        chk(cfg_err, 0, "R12", "cfg error");
        chk(irq_exc_start | rst_exc_start, 0, "R12", "start pulses");

        // R11 nap
        deep_en = 1'b0; sleep_req = 1'b1; tick(); sleep_req = 1'b0;
        chk(cpu_clk_en, 0, "R11", "nap cpu clock");
        chk(periph_clk_en, 1, "R11", "nap periph clock");
        chk(periph_rst, 0, "R11", "nap periph reset");
        irq_en = 8'h00; irq_req = 8'hFF; tick();
        chk(cpu_clk_en, 0, "R11", "disabled request in nap");
        irq_en = 8'h08; irq_req = 8'h08; tick(); irq_req = 8'h00;
        chk(cpu_clk_en, 1, "R11", "nap wake clock");
        chk(irq_exc_start, 1, "R11", "nap wake irq start");
        tick();

        // R1: sleep strobe while in deep standby is ignored
        enter_deep(8'h01, 3'd0);
        deep_en = 1'b0; sleep_req = 1'b1; tick(); sleep_req = 1'b0;
        chk(periph_clk_en, 0, "R1", "sleep strobe in deep ignored");
        chk(osc_en, 0, "R1", "osc after ignored strobe");
        // R4: key line wakes through line 6
        irq_en = 8'h40; key_in = 16'h0200; tick(); key_in = '0;
        chk(osc_en, 1, "R4", "key wake starts osc");
        count_settle(3'd0, 1'b0);

        // R8: reset pin in deep
        enter_deep(8'h00, 3'd1);
        rst_pin_n = 1'b0; tick();
        chk(osc_en, 1, "R8", "osc on with reset low");
        chk(cpu_clk_en, 0, "R8", "cpu gated with reset low");
        tick(); tick();
        chk(rst_exc_start, 0, "R8", "no start while low");
        rst_pin_n = 1'b1; tick();
        chk(rst_exc_start, 1, "R8", "reset start on release");
        chk(cpu_clk_en, 1, "R8", "clock after reset exit");
        chk(retain, 1, "R8", "retain after reset exit");
        tick();

        // R8: reset pin aborts a settle countdown
        enter_deep(8'h00, 3'd7);
        nmi = 1'b1; tick(); nmi = 1'b0;
        tick(); tick();
        rst_pin_n = 1'b0; tick();
        repeat (3) tick();
        rst_pin_n = 1'b1; tick();
        chk(rst_exc_start, 1, "R8", "reset start after aborted settle");
        chk(irq_exc_start, 0, "R8", "no irq start after abort");
        tick();

        // same cycle: wake and reset pin low -> reset path wins
        enter_deep(8'h00, 3'd0);
        nmi = 1'b1; rst_pin_n = 1'b0; tick(); nmi = 1'b0;
        repeat (10) tick();
        chk(cpu_clk_en, 0, "R8", "reset low beats wake");
        chk(irq_exc_start, 0, "R8", "no irq start under reset");
        rst_pin_n = 1'b1; tick();
        chk(rst_exc_start, 1, "R8", "reset start after tie");
        tick();

        // same cycle: wake and hold pin low -> hold wins
        enter_deep(8'h01, 3'd0);
        nmi = 1'b1; hold_pin_n = 1'b0; tick(); nmi = 1'b0;
        chk(hw_hold, 1, "R9", "hold beats wake");
        chk(osc_en, 0, "R9", "osc off in hold");
        chk(retain, 0, "R9", "retain cleared in hold");
        chk(periph_rst, 1, "R9", "periph reset in hold");
        tick();
        chk(hw_hold, 1, "R9", "hold persists");
        hold_pin_n = 1'b1; tick();
        chk(hw_hold, 0, "R10", "hold released");
        chk(osc_en, 1, "R10", "osc on after hold");
        chk(periph_rst, 1, "R10", "reset wait after hold");
        tick();
        chk(rst_exc_start, 1, "R10", "reset start after hold");
        chk(cpu_clk_en, 1, "R10", "clock after hold exit");
        chk(retain, 0, "R10", "retain stays cleared");
        tick();

        // R9 from run
        hold_pin_n = 1'b0; tick();
        chk(hw_hold, 1, "R9", "hold from run");
        chk(cpu_clk_en, 0, "R9", "cpu gated in hold");
        hold_pin_n = 1'b1; tick(); tick(); tick();

        // constrained random deep-standby rounds
        for (int it = 0; it < 40; it++) begin
            logic [7:0]    en, rq;
            logic [2:0]    sel;
            logic [KL-1:0] k;
            bit            n, w;
            en  = 8'($urandom);
            sel = 3'($urandom % 8);
            n   = ($urandom % 4 == 0);
            rq  = 8'($urandom);
            k   = ($urandom % 3 == 0) ? KL'(1) << ($urandom % KL) : '0;
            w   = exp_wake(n, rq, en, k);
            enter_deep(en, sel);
            nmi = n; irq_req = rq; key_in = k;
            tick();
            nmi = 1'b0; irq_req = 8'h00; key_in = '0;
            if (w) begin
                chk(osc_en, 1, "R4", "qualified wake");
            end else begin
                chk(osc_en, 0, "R5", "unqualified lines do not wake");
                chk(periph_clk_en, 0, "R5", "still in deep");
                nmi = 1'b1; tick(); nmi = 1'b0;
            end
            count_settle(sel, (it % 3 == 0));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule